// File: doc/BRIEF.md
# Rotate, Shift and Swap Unit

This is a purely combinational bit-manipulation unit for an 8-bit processor datapath. It takes one operand, the current carry flag and a 4-bit operation code. In the same cycle it returns the transformed operand and a new set of four condition flags: zero, subtract, half-carry and carry.

The operations are:
- single-bit rotates, plain or through the carry, in both directions;
- a left shift with zero fill;
- a right shift that either keeps the sign bit or fills with zero;
- an exchange of the two halves of the operand.

Each rotate exists in two flavours. The accumulator flavour always reports a clear zero flag. The general-register flavour sets the zero flag from the result.

Choosing the source register and sequencing a memory read-modify-write are left to the surrounding core. The operand width is a parameter and must be even. The swap exchanges its two halves, and the edge bits are always its top and bottom bits.

Top module: `rss_unit`

## Requirements
- R1: The operation code selects: 0 acc-rotate-left, 1 acc-rotate-right, 2 acc-rotate-left-through-carry, 3 acc-rotate-right-through-carry, 4 rotate-left, 5 rotate-right, 6 rotate-left-through-carry, 7 rotate-right-through-carry, 8 shift-left, 9 arithmetic-shift-right, 10 logical-shift-right, 11 swap halves.
- R2: Codes 0 and 4 move every bit up one place. The top bit goes both to bit 0 and to the carry output.
- R3: Codes 1 and 5 move every bit down one place. Bit 0 goes both to the top bit and to the carry output.
- R4: Codes 2 and 6 move every bit up one place. The incoming carry enters bit 0, and the old top bit becomes the carry output.
- R5: Codes 3 and 7 move every bit down one place. The incoming carry enters the top bit, and the old bit 0 becomes the carry output.
- R6: For codes 0 to 3 the zero flag output is 0, even when the result is all zeros.
- R7: For codes 4 to 15 the zero flag output is 1 exactly when the result is all zeros.
- R8: The subtract and half-carry flag outputs are 0 for every code.
- R9: Code 8 moves bits up one place with 0 entering bit 0, and the carry output takes the old top bit.
- R10: Code 9 moves bits down one place with the top bit unchanged, and the carry output takes the old bit 0.
- R11: Code 10 moves bits down one place with 0 entering the top bit, and the carry output takes the old bit 0.
- R12: Code 11 exchanges the upper and lower halves of the operand and drives the carry output to 0.
- R13: Codes 12 to 15 return the operand unchanged, and the carry output equals the incoming carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | DATA_W | Value to transform |
| carryIn | input | 1 | Current carry flag |
| opCode | input | 4 | Operation select, encoded as in R1 |
| result | output | DATA_W | Transformed value |
| flagZ | output | 1 | New zero flag |
| flagN | output | 1 | New subtract flag |
| flagH | output | 1 | New half-carry flag |
| flagC | output | 1 | New carry flag |

## Verification
The bench builds the unit with DATA_W = 8, the width the unit serves in the core. At that width every operand value can be applied with both carry inputs under all sixteen codes, so the sweep is exhaustive. That brings within reach:
- the all-zero result that separates the accumulator rotates from the general ones;
- top-bit and bottom-bit patterns that exercise each fill source;
- the four undefined codes.

Directed cases at the start pin down the single-bit edge cases before the sweep.

// File: rtl/rss_pkg.sv
package rss_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ACC_ROL   = 4'd0,
    OP_ACC_ROR   = 4'd1,
    OP_ACC_ROLC  = 4'd2,
    OP_ACC_RORC  = 4'd3,
    OP_ROL       = 4'd4,
    OP_ROR       = 4'd5,
    OP_ROLC      = 4'd6,
    OP_RORC      = 4'd7,
    OP_SHL       = 4'd8,
    OP_ASHR      = 4'd9,
    OP_LSHR      = 4'd10,
    OP_SWAP      = 4'd11
  } op_e;

  // Source of the bit that enters the vacated edge position
  typedef enum logic [1:0] {
    FILL_ZERO  = 2'd0,
    FILL_WRAP  = 2'd1,
    FILL_CARRY = 2'd2,
    FILL_SIGN  = 2'd3
  } fill_e;

  typedef struct packed {
    logic  goLeft;
    logic  goRight;
    logic  swapNib;
    logic  passThru;
    fill_e fill;
    logic  forceZLow;
  } strobe_t;

endpackage

// File: rtl/rss_ctrl.sv
module rss_ctrl
  import rss_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output strobe_t         strobe
);

  always_comb begin
    strobe = '{goLeft: 1'b0, goRight: 1'b0, swapNib: 1'b0, passThru: 1'b1,
               fill: FILL_ZERO, forceZLow: 1'b0};
    case (opCode)
      OP_ACC_ROL, OP_ROL: begin
        strobe.goLeft   = 1'b1;
        strobe.passThru = 1'b0;
        strobe.fill     = FILL_WRAP;
      end
      OP_ACC_ROR, OP_ROR: begin
        strobe.goRight  = 1'b1;
        strobe.passThru = 1'b0;
        strobe.fill     = FILL_WRAP;
      end
      OP_ACC_ROLC, OP_ROLC: begin
        strobe.goLeft   = 1'b1;
        strobe.passThru = 1'b0;
        strobe.fill     = FILL_CARRY;
      end
      OP_ACC_RORC, OP_RORC: begin
        strobe.goRight  = 1'b1;
        strobe.passThru = 1'b0;
        strobe.fill     = FILL_CARRY;
      end
      OP_SHL: begin
        strobe.goLeft   = 1'b1;
        strobe.passThru = 1'b0;
      end
      OP_ASHR: begin
        strobe.goRight  = 1'b1;
        strobe.passThru = 1'b0;
        strobe.fill     = FILL_SIGN;
      end
      OP_LSHR: begin
        strobe.goRight  = 1'b1;
        strobe.passThru = 1'b0;
      end
      OP_SWAP: begin
        strobe.swapNib  = 1'b1;
        strobe.passThru = 1'b0;
      end
      default: ;
    endcase
    // accumulator forms occupy the lowest four codes
    if (opCode < OP_W'(4)) strobe.forceZLow = 1'b1;
  end

  // R1: exactly one action per code
  always_comb begin
    a_r1_single_action: assert ($onehot({strobe.goLeft, strobe.goRight,
                                         strobe.swapNib, strobe.passThru}))
      else $error("decode selects %0d actions",
                  $countones({strobe.goLeft, strobe.goRight, strobe.swapNib, strobe.passThru}));
  end

endmodule

// File: rtl/rss_datapath.sv
module rss_datapath
  import rss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  strobe_t           strobe,
  output logic [DATA_W-1:0] result,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagH,
  output logic              flagC
);

  localparam int MSB    = DATA_W - 1;
  localparam int HALF_W = DATA_W / 2;

  logic fillBit;

  always_comb begin
    case (strobe.fill)
      FILL_WRAP:  fillBit = strobe.goLeft ? operand[MSB] : operand[0];
      FILL_CARRY: fillBit = carryIn;
      FILL_SIGN:  fillBit = operand[MSB];
      default:    fillBit = 1'b0;
    endcase
  end

  always_comb begin
    if (strobe.goLeft) begin
      result = {operand[MSB-1:0], fillBit};
      flagC  = operand[MSB];
    end else if (strobe.goRight) begin
      result = {fillBit, operand[MSB:1]};
      flagC  = operand[0];
    end else if (strobe.swapNib) begin
      result = {operand[HALF_W-1:0], operand[MSB:HALF_W]};
      flagC  = 1'b0;
    end else begin
      result = operand;
      flagC  = carryIn;
    end
  end

  assign flagZ = ~strobe.forceZLow & ~|result;
  assign flagN = 1'b0;
  assign flagH = 1'b0;

  always_comb begin
    // R2/R3: a wrap rotate neither creates nor loses set bits
    if (strobe.fill == FILL_WRAP) begin
      a_r2_wrap_keeps_ones: assert ($countones(result) == $countones(operand))
        else $error("wrap rotate changed bit count");
    end
    // R4/R5: through-carry rotate conserves ones across carry and data
    if (strobe.fill == FILL_CARRY) begin
      a_r4_carry_chain_kept: assert ($countones({flagC, result}) ==
                                     $countones({carryIn, operand}))
        else $error("carry rotate changed bit count");
    end
    // R10: arithmetic shift keeps the top bit
    if (strobe.fill == FILL_SIGN) begin
      a_r10_sign_kept: assert (result[MSB] == operand[MSB])
        else $error("sign bit lost");
    end
    // R12: swap clears carry and keeps the bit count
    if (strobe.swapNib) begin
      a_r12_swap_clean: assert (!flagC && $countones(result) == $countones(operand))
        else $error("swap corrupted data or carry");
    end
    // R6/R7: a set zero flag only ever accompanies an all-zero result
    if (flagZ) begin
      a_r7_zero_means_zero: assert (result == '0)
        else $error("zero flag with nonzero result");
    end
    // R8: subtract and half-carry stay low
    a_r8_nh_low: assert (!flagN && !flagH)
      else $error("N or H raised");
  end

endmodule

// File: rtl/rss_unit.sv
module rss_unit
  import rss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic [OP_W-1:0]   opCode,
  output logic [DATA_W-1:0] result,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagH,
  output logic              flagC
);

  strobe_t strobe;

  rss_ctrl i_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  rss_datapath #(.DATA_W(DATA_W)) i_datapath (
    .operand (operand),
    .carryIn (carryIn),
    .strobe  (strobe),
    .result  (result),
    .flagZ   (flagZ),
    .flagN   (flagN),
    .flagH   (flagH),
    .flagC   (flagC)
  );

endmodule

// File: tb/test_rss_unit.sv
module test_rss_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int WATCHDOG   = 50000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] operand = '0;
  logic              carryIn = 1'b0;
  logic [3:0]        opCode = '0;
  logic [DATA_W-1:0] result;
  logic              flagZ, flagN, flagH, flagC;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] expRes[$];
  logic       expZ[$];
  logic       expC[$];
  string      expTag[$];
  logic [7:0] seenIn[$];
  logic [3:0] seenOp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rss_unit #(.DATA_W(DATA_W)) i_rss_unit (
    .operand (operand),
    .carryIn (carryIn),
    .opCode  (opCode),
    .result  (result),
    .flagZ   (flagZ),
    .flagN   (flagN),
    .flagH   (flagH),
    .flagC   (flagC)
  );

  function automatic string tagFor(int op);
    string base;
    case (op)
      0, 4:    base = "R2";
      1, 5:    base = "R3";
      2, 6:    base = "R4";
      3, 7:    base = "R5";
      8:       base = "R9";
      9:       base = "R10";
      10:      base = "R11";
      11:      base = "R12";
      default: base = "R13";
    endcase
    return $sformatf("R1/%s/%s/R8", base, (op < 4) ? "R6" : "R7");
  endfunction

  // Driver: applies stimulus and queues the expected outcome
  task automatic apply(input int op, input int val, input int cin);
    int u, res, co;
    @(posedge clk);
    #1;
    opCode  = 4'(op);
    operand = 8'(val);
    carryIn = cin[0];
    u = val & 255;
    case (op)
      0, 4: begin res = ((u * 2) + (u / 128)) % 256; co = u / 128; end
      1, 5: begin res = (u / 2) + (u % 2) * 128;     co = u % 2;   end
      2, 6: begin res = ((u * 2) + cin) % 256;       co = u / 128; end
      3, 7: begin res = (u / 2) + cin * 128;         co = u % 2;   end
      8:    begin res = (u * 2) % 256;               co = u / 128; end
      9:    begin res = (u / 2) + (u / 128) * 128;   co = u % 2;   end
      10:   begin res = u / 2;                       co = u % 2;   end
      11:   begin res = (u % 16) * 16 + (u / 16);    co = 0;       end
      default: begin res = u;                        co = cin;     end
    endcase
    expRes.push_back(8'(res));
    expZ.push_back((op >= 4) && (res == 0));
    expC.push_back(co[0]);
    expTag.push_back(tagFor(op));
    seenIn.push_back(8'(u));
    seenOp.push_back(4'(op));
  endtask

  // Monitor: compares at the falling edge, away from stimulus changes
  always @(negedge clk) begin
    if (!rst && expRes.size() > 0) begin
      logic [7:0] r;
      logic z, c;
      string t;
      logic [7:0] vin;
      logic [3:0] o;
      r = expRes.pop_front();
      z = expZ.pop_front();
      c = expC.pop_front();
      t = expTag.pop_front();
      vin = seenIn.pop_front();
      o = seenOp.pop_front();
      checks++;
      if (result !== r || flagZ !== z || flagC !== c || flagN !== 1'b0 || flagH !== 1'b0) begin
        fails++;
        $display("FAIL %s op=%0d in=%02h: got res=%02h ZNHC=%b%b%b%b expected res=%02h ZNHC=%b00%b",
                 t, o, vin, result, flagZ, flagN, flagH, flagC, r, z, c);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // reset state: code 0 on zero operand gives zero result, Z low (R6)
    apply(0, 8'h00, 0);
    // R2 edge: top bit wraps to bit 0 and carry
    apply(0, 8'h80, 0);
    apply(4, 8'h00, 1);              // R7 zero result sets Z
    apply(2, 8'h80, 0);              // R4 + R6 result zero but Z low
    apply(7, 8'h01, 0);              // R5 result zero, Z high
    apply(9, 8'h81, 0);              // R10 sign kept
    apply(10, 8'h81, 1);             // R11 zero fill
    apply(8, 8'hFF, 0);              // R9 zero into bit 0
    apply(11, 8'hF0, 1);             // R12 carry cleared
    apply(13, 8'h00, 1);             // R13 pass-through, carry kept
    apply(1, 8'h01, 0);              // R3 bit 0 wraps
    // exhaustive sweep of every code, operand and carry input
    for (int op = 0; op < 16; op++)
      for (int v = 0; v < 256; v++)
        for (int c = 0; c < 2; c++)
          apply(op, v, c);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule